// File: doc/BRIEF.md
# Per-Thread Issue-Queue Slot Allocator

This block tracks issue-queue slot usage in a processor core that runs several hardware threads at once. It holds no instructions. It keeps one occupancy counter per thread and one slot limit per thread, and it tells the rename/dispatch stage how many more instructions each thread may place into the shared queue. A sharing mode selects how the queue is divided among the threads. In the shared-pool mode, any thread may take every slot. In the even-split mode, the queue is divided evenly among the threads that are running. In the capped mode, each thread receives a fixed percentage of the queue, unless it is the only running thread.

Dispatch raises one insert pulse per thread for each instruction it wants to place. Commit raises a release pulse when an entry retires, and squash recovery raises a separate release pulse when an entry is flushed. The allocator decides which inserts are accepted. It updates the occupancy counters and publishes per-thread free counts, per-thread stall flags, the shared free count and a shared full flag. The limits are registered from the mode and the active-thread mask, so a change to either input takes effect at the next clock edge.

Top module: `iq_slot_alloc`

## Requirements
- R1: A synchronous active-high reset sets every occupancy to zero and sets `q_free` to NUM_ENTRIES. It clears `ins_err` and loads each limit from the `share_mode` and `active_mask` values present during reset.
- R2: When `share_mode` is 0 (shared pool), every thread's limit is NUM_ENTRIES. Code 3 behaves the same as code 0.
- R3: When `share_mode` is 1 (even split), every thread's limit is NUM_ENTRIES divided by the number of set bits in `active_mask`, truncated. An empty mask counts as NUM_THREADS.
- R4: When `share_mode` is 2 (capped), every thread's limit is NUM_ENTRIES*THRESH_PCT/100, truncated and saturated at NUM_ENTRIES.
- R5: In capped mode, when exactly one bit of `active_mask` is set, that thread's limit is NUM_ENTRIES. The other threads keep the capped limit.
- R6: Limits are registered. A change of `share_mode` or `active_mask` has no effect on any output until the next rising clock edge. Until then, a thread whose occupancy is at or above its old limit stays stalled.
- R7: Thread t's free count, in field `free_cnt[t*CW +: CW]`, equals its limit minus its occupancy, or zero when the occupancy is at or above the limit. `thr_full[t]` is set exactly when that count is zero.
- R8: `q_free` equals NUM_ENTRIES minus the sum of all occupancies, and `q_full` is set exactly when `q_free` is zero. Within one cycle, inserts are granted from the lowest thread index upward while shared room remains.
- R9: Each of `commit_rel[t]` and `squash_rel[t]` releases one entry of thread t. An occupancy never goes below zero. An accepted insert together with one release for the same thread leaves that thread's occupancy unchanged.
- R10: An insert is ignored when its thread is stalled or the shared room is used up. Such an insert sets `ins_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| share_mode | input | 2 | Sharing mode: 0 shared pool, 1 even split, 2 capped, 3 as 0 |
| active_mask | input | NUM_THREADS | One bit per running thread |
| ins_req | input | NUM_THREADS | Per-thread insert pulse |
| commit_rel | input | NUM_THREADS | Per-thread release on retirement |
| squash_rel | input | NUM_THREADS | Per-thread release on flush |
| free_cnt | output | NUM_THREADS*CW | Per-thread free slot counts, thread t in bits t*CW +: CW |
| thr_full | output | NUM_THREADS | Per-thread stall flag |
| q_full | output | 1 | Whole queue occupied |
| q_free | output | CW | Unused slots in the whole queue |
| ins_err | output | 1 | Sticky flag for ignored inserts |

CW is clog2(NUM_ENTRIES+1).

## Verification
The bench targets the moment a mask or mode change arrives. A design that applied limits combinationally would show the new free counts before the clock edge. It also drives all four threads to insert together against a nearly full queue. A grant chain that did not spend shared room in thread order would push `q_free` below zero, or would grant a higher thread ahead of a lower one. Directed steps cover several more cases: a lone thread in capped mode, which should get the full queue rather than the capped share; insert plus commit on the same thread in one cycle, where a missed cancellation makes the occupancy drift; a release on an empty thread, where a missing clamp makes the counter wrap; and inserts into a stalled thread, which must raise the sticky flag without changing the occupancy.

// File: rtl/iq_alloc_pkg.sv
package iq_alloc_pkg;

    typedef enum logic [1:0] {
        SHARE_POOL   = 2'd0,
        SHARE_SPLIT  = 2'd1,
        SHARE_CAPPED = 2'd2,
        SHARE_ALT    = 2'd3
    } share_e;

    // one thread's update request for a cycle
    typedef struct packed {
        logic grant;
        logic rel_commit;
        logic rel_squash;
    } thr_op_t;

    function automatic int unsigned bit_total(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += {31'd0, v[i]};
        end
        return n;
    endfunction

    function automatic int unsigned capped_share(input int unsigned entries,
                                                 input int unsigned pct);
        int unsigned c;
        c = (entries * pct) / 100;
        return (c > entries) ? entries : c;
    endfunction

endpackage

// File: rtl/iq_limit_calc.sv
module iq_limit_calc
    import iq_alloc_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int NUM_THREADS = 4,
    parameter int THRESH_PCT  = 50,
    parameter int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input  share_e                              mode,
    input  logic [NUM_THREADS-1:0]              mask,
    output logic [NUM_THREADS-1:0][CW-1:0]      lim
);
    localparam int unsigned CAP = capped_share(NUM_ENTRIES, THRESH_PCT);
    localparam logic [CW-1:0] FULL_LIM = CW'(NUM_ENTRIES);
    localparam logic [CW-1:0] CAP_LIM  = CW'(CAP);

    int unsigned    n_act;
    logic [CW-1:0]  split_lim;

    always_comb begin
        n_act = bit_total(32'(mask));
        split_lim = CW'(NUM_ENTRIES / NUM_THREADS);
        for (int k = 1; k <= NUM_THREADS; k++) begin
            if (n_act == k) begin
                split_lim = CW'(NUM_ENTRIES / k);
            end
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lim
        always_comb begin
            unique case (mode)
                SHARE_SPLIT:  lim[t] = split_lim;
                SHARE_CAPPED: lim[t] = (n_act == 1 && mask[t]) ? FULL_LIM : CAP_LIM;
                default:      lim[t] = FULL_LIM;
            endcase
        end
    end

endmodule

// File: rtl/iq_occ_track.sv
module iq_occ_track
    import iq_alloc_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  thr_op_t        op,
    output logic [CW-1:0]  occ
);
    logic [CW:0] up_val;
    logic [CW:0] drop_val;
    logic [CW:0] nxt_val;

    always_comb begin
        up_val   = {1'b0, occ} + {{CW{1'b0}}, op.grant};
        drop_val = {{CW{1'b0}}, op.rel_commit} + {{CW{1'b0}}, op.rel_squash};
        nxt_val  = (up_val >= drop_val) ? (up_val - drop_val) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= nxt_val[CW-1:0];
        end
    end

endmodule

// File: rtl/iq_slot_alloc.sv
module iq_slot_alloc
    import iq_alloc_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int NUM_THREADS = 4,
    parameter int THRESH_PCT  = 50,
    localparam int CW         = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  share_mode,
    input  logic [NUM_THREADS-1:0]      active_mask,
    input  logic [NUM_THREADS-1:0]      ins_req,
    input  logic [NUM_THREADS-1:0]      commit_rel,
    input  logic [NUM_THREADS-1:0]      squash_rel,
    output logic [NUM_THREADS*CW-1:0]   free_cnt,
    output logic [NUM_THREADS-1:0]      thr_full,
    output logic                        q_full,
    output logic [CW-1:0]               q_free,
    output logic                        ins_err
);
    localparam int SW = $clog2(NUM_ENTRIES * NUM_THREADS + 1);

    share_e                             mode_s;
    logic [NUM_THREADS-1:0][CW-1:0]     lim_next;
    logic [NUM_THREADS-1:0][CW-1:0]     lim_q;
    logic [NUM_THREADS-1:0][CW-1:0]     occ_q;
    logic [NUM_THREADS-1:0][CW-1:0]     free_2d;
    logic [NUM_THREADS-1:0]             grant;
    logic [NUM_THREADS-1:0]             reject;
    thr_op_t [NUM_THREADS-1:0]          ops;
    logic [SW-1:0]                      used_sum;
    logic [CW-1:0]                      room;

    assign mode_s = share_e'(share_mode);

    iq_limit_calc #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .NUM_THREADS (NUM_THREADS),
        .THRESH_PCT  (THRESH_PCT),
        .CW          (CW)
    ) u_lim (
        .mode (mode_s),
        .mask (active_mask),
        .lim  (lim_next)
    );

    // limits follow the mode and mask one edge later; reset loads them too
    always_ff @(posedge clk) begin
        lim_q <= lim_next;
    end

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            free_2d[t]  = (lim_q[t] > occ_q[t]) ? (lim_q[t] - occ_q[t]) : '0;
            thr_full[t] = (free_2d[t] == '0);
        end
    end

    assign free_cnt = free_2d;

    always_comb begin
        used_sum = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            used_sum = used_sum + SW'(occ_q[t]);
        end
    end

    assign q_free = CW'(NUM_ENTRIES) - used_sum[CW-1:0];
    assign q_full = (q_free == '0);

    // grant chain: lower thread index claims shared room first
    always_comb begin
        room = q_free;
        for (int t = 0; t < NUM_THREADS; t++) begin
            grant[t]  = 1'b0;
            reject[t] = 1'b0;
            if (ins_req[t]) begin
                if (!thr_full[t] && room != '0) begin
                    grant[t] = 1'b1;
                    room     = room - 1'b1;
                end else begin
                    reject[t] = 1'b1;
                end
            end
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_occ
        assign ops[t] = '{grant: grant[t], rel_commit: commit_rel[t],
                          rel_squash: squash_rel[t]};

        iq_occ_track #(
            .NUM_ENTRIES (NUM_ENTRIES),
            .CW          (CW)
        ) u_occ (
            .clk (clk),
            .rst (rst),
            .op  (ops[t]),
            .occ (occ_q[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_err <= 1'b0;
        end else if (|reject) begin
            ins_err <= 1'b1;
        end
    end

endmodule

// File: rtl/iq_alloc_chk.sv
module iq_alloc_chk #(
    parameter int NUM_ENTRIES = 32,
    parameter int NUM_THREADS = 4,
    parameter int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_THREADS-1:0]           ins_req,
    input logic [NUM_THREADS-1:0]           commit_rel,
    input logic [NUM_THREADS-1:0]           squash_rel,
    input logic [NUM_THREADS-1:0]           thr_full,
    input logic                             q_full,
    input logic [CW-1:0]                    q_free,
    input logic                             ins_err,
    input logic [NUM_THREADS-1:0][CW-1:0]   occ
);
    // R8
    q_free_range_chk: assert property (@(posedge clk) disable iff (rst)
        q_free <= CW'(NUM_ENTRIES));

    // R8
    shared_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q_full && commit_rel == '0 && squash_rel == '0) |=> q_full);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ins_err |=> ins_err);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        // R10
        stalled_insert_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (ins_req[t] && thr_full[t]) |=> ins_err);

        // R10
        stalled_insert_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (ins_req[t] && thr_full[t] && !commit_rel[t] && !squash_rel[t])
            |=> $stable(occ[t]));

        // R9
        occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
            occ[t] <= CW'(NUM_ENTRIES));
    end

endmodule

bind iq_slot_alloc iq_alloc_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_THREADS (NUM_THREADS),
    .CW          (CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ins_req    (ins_req),
    .commit_rel (commit_rel),
    .squash_rel (squash_rel),
    .thr_full   (thr_full),
    .q_full     (q_full),
    .q_free     (q_free),
    .ins_err    (ins_err),
    .occ        (occ_q)
);

// File: tb/tb_iq_slot_alloc.sv
`timescale 1ns/1ps
module tb_iq_slot_alloc;
    localparam int N   = 32;
    localparam int T   = 4;
    localparam int PCT = 50;
    localparam int CW  = $clog2(N + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     share_mode = 2'd0;
    logic [T-1:0]   active_mask = '1;
    logic [T-1:0]   ins_req = '0;
    logic [T-1:0]   commit_rel = '0;
    logic [T-1:0]   squash_rel = '0;
    logic [T*CW-1:0] free_cnt;
    logic [T-1:0]   thr_full;
    logic           q_full;
    logic [CW-1:0]  q_free;
    logic           ins_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_occ [T];
    int m_lim [T];
    bit m_err;

    always #2.5 clk = ~clk;

    iq_slot_alloc #(.NUM_ENTRIES(N), .NUM_THREADS(T), .THRESH_PCT(PCT)) dut (
        .clk(clk), .rst(rst), .share_mode(share_mode), .active_mask(active_mask),
        .ins_req(ins_req), .commit_rel(commit_rel), .squash_rel(squash_rel),
        .free_cnt(free_cnt), .thr_full(thr_full), .q_full(q_full),
        .q_free(q_free), .ins_err(ins_err)
    );

    function automatic int spec_lim(input logic [1:0] md, input logic [T-1:0] mk, input int t);
        int na, cap;
        na = 0;
        for (int i = 0; i < T; i++) na += int'(mk[i]);
        cap = (N * PCT) / 100;
        if (cap > N) cap = N;
        case (md)
            2'd1: return (na == 0) ? N / T : N / na;
            2'd2: return (na == 1 && mk[t]) ? N : cap;
            default: return N;
        endcase
    endfunction

    function automatic int spec_free(input int t);
        return (m_lim[t] > m_occ[t]) ? m_lim[t] - m_occ[t] : 0;
    endfunction

    function automatic int spec_room();
        int s;
        s = 0;
        for (int t = 0; t < T; t++) s += m_occ[t];
        return N - s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int dut_free(input int t);
        return int'(free_cnt[t*CW +: CW]);
    endfunction

    task automatic check_all();
        for (int t = 0; t < T; t++) begin
            chk("R7 free count", dut_free(t), spec_free(t));
            chk("R7 thread stall", int'(thr_full[t]), int'(spec_free(t) == 0));
        end
        chk("R8 shared free", int'(q_free), spec_room());
        chk("R8 shared full", int'(q_full), int'(spec_room() == 0));
        chk("R10 error flag", int'(ins_err), int'(m_err));
    endtask

    // model of the next state from the present inputs, applied at the coming edge
    task automatic model_step();
        int room;
        room = spec_room();
        for (int t = 0; t < T; t++) begin
            int g, v;
            g = 0;
            if (ins_req[t]) begin
                if (spec_free(t) != 0 && room != 0) begin
                    g = 1;
                    room--;
                end else begin
                    m_err = 1;
                end
            end
            v = m_occ[t] + g - int'(commit_rel[t]) - int'(squash_rel[t]);
            m_occ[t] = (v < 0) ? 0 : v;
        end
        for (int t = 0; t < T; t++) m_lim[t] = spec_lim(share_mode, active_mask, t);
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        ins_req = '0; commit_rel = '0; squash_rel = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        for (int t = 0; t < T; t++) begin
            m_occ[t] = 0;
            m_lim[t] = spec_lim(share_mode, active_mask, t);
        end
        m_err = 0;
        // R1 reset state
        chk("R1 reset shared free", int'(q_free), N);
        chk("R1 reset err", int'(ins_err), 0);
        check_all();
        rst = 1'b0;

        // R2 shared pool
        cycle();
        chk("R2 pool limit", dut_free(2), N);
        share_mode = 2'd3;
        cycle();
        chk("R2 code 3 pool limit", dut_free(1), N);

        // R3 even split with two threads running, R6 latency
        share_mode = 2'd1; active_mask = 4'b0011;
        #1;
        chk("R6 limit unchanged before edge", dut_free(0), N);
        cycle();
        chk("R3 split of two", dut_free(0), N / 2);
        active_mask = 4'b0111;
        cycle();
        chk("R3 split of three", dut_free(3), N / 3);
        active_mask = 4'b0000;
        cycle();
        chk("R3 empty mask", dut_free(1), N / T);

        // R4 capped, R5 lone thread
        share_mode = 2'd2; active_mask = 4'b1111;
        cycle();
        chk("R4 capped limit", dut_free(0), (N * PCT) / 100);
        active_mask = 4'b0100;
        cycle();
        chk("R5 lone thread full queue", dut_free(2), N);
        chk("R5 other thread capped", dut_free(0), (N * PCT) / 100);

        // R9 insert plus release on same thread
        share_mode = 2'd1; active_mask = 4'b1111;
        ins_req = 4'b0001;
        repeat (3) cycle();
        ins_req = 4'b0001; commit_rel = 4'b0001;
        cycle();
        chk("R9 insert with release", dut_free(0), N / T - 3);
        idle(); squash_rel = 4'b0010; commit_rel = 4'b0010;
        cycle();
        chk("R9 release on empty thread", dut_free(1), N / T);

        // R10 stall thread 1 then overfill it; R6 stall kept through limit drop
        idle(); ins_req = 4'b0010;
        repeat (N / T + 2) cycle();
        chk("R10 stalled thread free", dut_free(1), 0);
        chk("R10 sticky flag", int'(ins_err), 1);
        idle(); share_mode = 2'd0;
        #1;
        chk("R6 stall held before edge", int'(thr_full[1]), 1);
        cycle();
        chk("R6 pool after edge", dut_free(1), N - N / T);

        // R8 four threads racing for the last slots
        ins_req = 4'b1111;
        repeat (10) cycle();
        chk("R8 shared queue full", int'(q_full), 1);
        idle();

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) share_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 31) == 0) active_mask = T'($urandom);
            ins_req    = T'($urandom) & T'($urandom | $urandom);
            commit_rel = T'($urandom) & T'($urandom);
            squash_rel = ($urandom_range(0, 7) == 0) ? T'($urandom) : '0;
            cycle();
        end
        idle();
        cycle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule